// File: doc/BRIEF.md
# Codec Command Slot Controller

This block turns two software-visible slot words into single accesses on a codec's register port. Software first places a data word in the second transmit slot. It then writes an address and direction word to the first transmit slot. The write to the first slot starts one codec register access: a write when the direction bit is clear, a read when it is set.

A read fills two receive slot registers. The first holds the command word with its direction bit cleared. The second holds the returned register value, shifted up into the slot's data field. A byte of flag bits reports transmit-empty, receive-busy, receive-valid and command-pending state, so that software can poll for progress.

The codec side is a plain synchronous register port. An enable is held for one cycle. The codec takes a write on the clock edge that ends that cycle. For a read, it registers the requested value on that same edge, so the value is present during the following cycle.

Top module: `codec_slot_ctrl`

## Requirements
- R1: After reset, `slot_flags` reads 8'h07 (transmit-1-empty bit 0, transmit-2-empty bit 1, both-empty bit 2 set; all others clear), and both receive slot registers read zero.
- R2: A write to select 1 (transmit slot 2) stores the 20-bit word, clears flag bit 1 and starts no codec access.
- R3: A write to select 0 (transmit slot 1) while no command is pending clears flag bit 0 and, when word bit 19 is 0, drives `cdc_we` in the next cycle with address = word bits 18:12 and write data = transmit slot 2 bits 19:4 as they stood at launch.
- R4: When bit 19 of the accepted slot-1 word is 1, `cdc_re` is driven in the next cycle with the address taken from bits 18:12.
- R5: A read completes two clock edges after launch: receive slot 1 (select 2) holds the slot-1 word with bit 19 cleared, and receive slot 2 (select 3) holds the codec value in bits 19:4 with bits 3:0 zero.
- R6: Both receive-busy flags (bits 3 and 4) are set from the read launch until completion; completion clears them and sets both receive-valid flags (bits 5 and 6).
- R7: Flag bit 7 is set while a codec access is outstanding, which is one cycle for a write and two for a read. A slot-1 write during that time is ignored: the slot-1 register is left unchanged and no access is started.
- R8: Reading select 2 clears flag bit 5, and reading select 3 clears flag bit 6. If a read completes in the same cycle, the set takes priority.
- R9: Flag bit 2 is the AND of flag bits 0 and 1.
- R10: `cdc_we` and `cdc_re` are never both high, and each stays high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe (clears the receive-valid flag of the register read) |
| sw_sel | input | 2 | Slot select: 0 transmit 1, 1 transmit 2, 2 receive 1, 3 receive 2 |
| sw_wdata | input | 20 | Software write word |
| sw_rdata | output | 20 | Selected slot register, combinational |
| slot_flags | output | 8 | Flag bits, layout as in R1, R6, R7 |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec write data |
| cdc_we | output | 1 | Codec write enable, one cycle |
| cdc_re | output | 1 | Codec read enable, one cycle |
| cdc_rdata | input | 16 | Codec read data, valid the cycle after `cdc_re` |

## Verification
The bench builds the block with its default widths: a 7-bit address, a 16-bit data field and a 4-bit pad. These defaults give the 20-bit slot word, with the direction flag at bit 19, the address at 18:12 and the data at 19:4. With them the bench can reach the extreme address 7'h7F and all-ones data, where a one-bit slip in a field boundary shows. The defaults also give the exact two-edge read latency, so the bench can place a second launch inside the pending window. The same latency lets it place a receive-register read on the very edge where a read completes.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

  // slot select codes
  localparam logic [1:0] SEL_TX1 = 2'd0;
  localparam logic [1:0] SEL_TX2 = 2'd1;
  localparam logic [1:0] SEL_RX1 = 2'd2;
  localparam logic [1:0] SEL_RX2 = 2'd3;

  // flag bit layout
  localparam int unsigned FLAG_W       = 8;
  localparam int unsigned FLG_TX1_EMPT = 0;
  localparam int unsigned FLG_TX2_EMPT = 1;
  localparam int unsigned FLG_TXB_EMPT = 2;
  localparam int unsigned FLG_RX_BUSY0 = 3;
  localparam int unsigned FLG_RX_VAL0  = 5;
  localparam int unsigned FLG_PENDING  = 7;
  localparam int unsigned NUM_RX       = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cslot_txregs.sv
module cslot_txregs #(
  parameter int unsigned SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx1_load,
  input  logic              tx2_load,
  input  logic [SLOT_W-1:0] wdata,
  output logic [SLOT_W-1:0] tx1_q,
  output logic [SLOT_W-1:0] tx2_q,
  output logic              tx1_empty,
  output logic              tx2_empty
);

  logic [SLOT_W-1:0] tx1_d, tx2_d;
  logic              tx1_empty_d, tx2_empty_d;

  always_comb begin
    tx1_d       = tx1_q;
    tx2_d       = tx2_q;
    tx1_empty_d = tx1_empty;
    tx2_empty_d = tx2_empty;
    if (tx1_load) begin
      tx1_d       = wdata;
      tx1_empty_d = 1'b0;
    end
    if (tx2_load) begin
      tx2_d       = wdata;
      tx2_empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx1_q     <= '0;
      tx2_q     <= '0;
      tx1_empty <= 1'b1;
      tx2_empty <= 1'b1;
    end else begin
      tx1_q     <= tx1_d;
      tx2_q     <= tx2_d;
      tx1_empty <= tx1_empty_d;
      tx2_empty <= tx2_empty_d;
    end
  end

  // R2
  tx2_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx2_load |=> (!tx2_empty && tx2_q == $past(wdata)));

endmodule

// File: rtl/cslot_seq.sv
module cslot_seq
  import cslot_pkg::*;
#(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx1_req,
  input  logic [SLOT_W-1:0] wdata,
  input  logic [DATA_W-1:0] tx2_data,
  output logic              accept,
  output logic              pending,
  output logic              rd_launch,
  output logic              rd_done,
  output logic [SLOT_W-1:0] cmd_word,
  output logic [ADDR_W-1:0] cdc_addr,
  output logic [DATA_W-1:0] cdc_wdata,
  output logic              cdc_we,
  output logic              cdc_re
);

  localparam int unsigned RW_BIT  = SLOT_W - 1;
  localparam int unsigned ADDR_HI = RW_BIT - 1;
  localparam int unsigned ADDR_LO = RW_BIT - ADDR_W;

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] cmd_q;
  logic [DATA_W-1:0] wdat_q;
  logic              issuing;

  assign accept    = tx1_req && (state_q == SEQ_IDLE);
  assign rd_launch = accept && wdata[RW_BIT];
  assign issuing   = (state_q == SEQ_ISSUE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (accept) state_d = SEQ_ISSUE;
      SEQ_ISSUE: state_d = cmd_q[RW_BIT] ? SEQ_WAIT : SEQ_IDLE;
      SEQ_WAIT:  state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cmd_q   <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cmd_q  <= wdata;
        wdat_q <= tx2_data;
      end
    end
  end

  assign pending   = (state_q != SEQ_IDLE);
  assign rd_done   = (state_q == SEQ_WAIT);
  assign cmd_word  = cmd_q;
  assign cdc_addr  = cmd_q[ADDR_HI:ADDR_LO];
  assign cdc_wdata = wdat_q;
  assign cdc_we    = issuing && !cmd_q[RW_BIT];
  assign cdc_re    = issuing && cmd_q[RW_BIT];

  // R3
  wr_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wdata[RW_BIT]) |=> (cdc_we && !cdc_re && cdc_wdata == $past(tx2_data)
                                    && cdc_addr == $past(wdata[ADDR_HI:ADDR_LO])));
  // R4
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wdata[RW_BIT]) |=> (cdc_re && !cdc_we
                                   && cdc_addr == $past(wdata[ADDR_HI:ADDR_LO])));
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_we || cdc_re) |=> !(cdc_we || cdc_re));
  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && tx1_req) |=> !(cdc_we || cdc_re));

endmodule

// File: rtl/cslot_rx.sv
module cslot_rx
  import cslot_pkg::*;
#(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_launch,
  input  logic              rd_done,
  input  logic [SLOT_W-1:0] cmd_word,
  input  logic [DATA_W-1:0] cdc_rdata,
  input  logic [NUM_RX-1:0] sw_clr,
  output logic [SLOT_W-1:0] rx1_q,
  output logic [SLOT_W-1:0] rx2_q,
  output logic [NUM_RX-1:0] busy,
  output logic [NUM_RX-1:0] valid
);

  localparam int unsigned PAD_W  = SLOT_W - DATA_W;
  localparam int unsigned RW_BIT = SLOT_W - 1;

  logic [SLOT_W-1:0] rx1_d, rx2_d;

  always_comb begin
    rx1_d = rx1_q;
    rx2_d = rx2_q;
    if (rd_done) begin
      rx1_d         = cmd_word;
      rx1_d[RW_BIT] = 1'b0;
      rx2_d         = {cdc_rdata, {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx1_q <= '0;
      rx2_q <= '0;
    end else begin
      rx1_q <= rx1_d;
      rx2_q <= rx2_d;
    end
  end

  for (genvar g = 0; g < NUM_RX; g++) begin : g_slot_flags
    logic busy_d, valid_d;

    always_comb begin
      busy_d  = busy[g];
      valid_d = valid[g];
      if (rd_launch) busy_d = 1'b1;
      if (sw_clr[g]) valid_d = 1'b0;
      if (rd_done) begin
        busy_d  = 1'b0;
        valid_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[g]  <= 1'b0;
        valid[g] <= 1'b0;
      end else begin
        busy[g]  <= busy_d;
        valid[g] <= valid_d;
      end
    end

    // R8
    valid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[g] && !rd_done) |=> !valid[g]);
  end

  // R6
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (valid == '1 && busy == '0));
  // R6
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_launch |=> (busy == '1));

endmodule

// File: rtl/codec_slot_ctrl.sv
module codec_slot_ctrl
  import cslot_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PAD_W  = 4,
  localparam int unsigned SLOT_W = DATA_W + PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_rd,
  input  logic [1:0]        sw_sel,
  input  logic [SLOT_W-1:0] sw_wdata,
  output logic [SLOT_W-1:0] sw_rdata,
  output logic [FLAG_W-1:0] slot_flags,
  output logic [ADDR_W-1:0] cdc_addr,
  output logic [DATA_W-1:0] cdc_wdata,
  output logic              cdc_we,
  output logic              cdc_re,
  input  logic [DATA_W-1:0] cdc_rdata
);

  logic              tx1_req, tx2_load, accept, pending, rd_launch, rd_done;
  logic [SLOT_W-1:0] tx1_q, tx2_q, rx1_q, rx2_q, cmd_word;
  logic              tx1_empty, tx2_empty;
  logic [NUM_RX-1:0] rx_busy, rx_valid, sw_clr;

  assign tx1_req   = sw_wr && (sw_sel == SEL_TX1);
  assign tx2_load  = sw_wr && (sw_sel == SEL_TX2);
  assign sw_clr[0] = sw_rd && (sw_sel == SEL_RX1);
  assign sw_clr[1] = sw_rd && (sw_sel == SEL_RX2);

  cslot_txregs #(.SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .tx1_load(accept), .tx2_load(tx2_load), .wdata(sw_wdata),
    .tx1_q(tx1_q), .tx2_q(tx2_q),
    .tx1_empty(tx1_empty), .tx2_empty(tx2_empty)
  );

  cslot_seq #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tx1_req(tx1_req), .wdata(sw_wdata),
    .tx2_data(tx2_q[SLOT_W-1 -: DATA_W]),
    .accept(accept), .pending(pending),
    .rd_launch(rd_launch), .rd_done(rd_done), .cmd_word(cmd_word),
    .cdc_addr(cdc_addr), .cdc_wdata(cdc_wdata),
    .cdc_we(cdc_we), .cdc_re(cdc_re)
  );

  cslot_rx #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rd_launch(rd_launch), .rd_done(rd_done),
    .cmd_word(cmd_word), .cdc_rdata(cdc_rdata), .sw_clr(sw_clr),
    .rx1_q(rx1_q), .rx2_q(rx2_q), .busy(rx_busy), .valid(rx_valid)
  );

  always_comb begin
    unique case (sw_sel)
      SEL_TX1: sw_rdata = tx1_q;
      SEL_TX2: sw_rdata = tx2_q;
      SEL_RX1: sw_rdata = rx1_q;
      default: sw_rdata = rx2_q;
    endcase
  end

  always_comb begin
    slot_flags                                  = '0;
    slot_flags[FLG_TX1_EMPT]                    = tx1_empty;
    slot_flags[FLG_TX2_EMPT]                    = tx2_empty;
    slot_flags[FLG_TXB_EMPT]                    = tx1_empty && tx2_empty;
    slot_flags[FLG_RX_BUSY0 +: NUM_RX]          = rx_busy;
    slot_flags[FLG_RX_VAL0 +: NUM_RX]           = rx_valid;
    slot_flags[FLG_PENDING]                     = pending;
  end

  // R7
  tx1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx1_req && pending) |=> $stable(tx1_q));
  // R10
  enable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cdc_we && cdc_re));

endmodule

// File: tb/codec_slot_ctrl_tb_top.sv
module codec_slot_ctrl_tb_top;

  localparam int unsigned SW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_wr = 1'b0, sw_rd = 1'b0;
  logic [1:0]    sw_sel = 2'd0;
  logic [SW-1:0] sw_wdata = '0;
  logic [SW-1:0] sw_rdata;
  logic [7:0]    slot_flags;
  logic [6:0]    cdc_addr;
  logic [15:0]   cdc_wdata;
  logic          cdc_we, cdc_re;
  logic [15:0]   cdc_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed { logic rd; logic [6:0] addr; logic [15:0] data; } op_t;
  op_t exp_q[$];

  logic [15:0] cmem [128];

  always #2.5 clk = ~clk;

  codec_slot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .slot_flags(slot_flags),
    .cdc_addr(cdc_addr), .cdc_wdata(cdc_wdata), .cdc_we(cdc_we),
    .cdc_re(cdc_re), .cdc_rdata(cdc_rdata)
  );

  // codec register model
  initial for (int i = 0; i < 128; i++) cmem[i] = 16'h1000 + 16'(i);
  always @(posedge clk) begin
    if (cdc_we) cmem[cdc_addr] <= cdc_wdata;
    if (cdc_re) cdc_rdata <= cmem[cdc_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected codec accesses
  logic prev_en = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cdc_we || cdc_re) begin
        chk("R10 exclusive enables", {31'd0, cdc_we && cdc_re}, 32'd0);
        chk("R10 one-cycle enable", {31'd0, prev_en}, 32'd0);
        if (exp_q.size() == 0) begin
          chk("R7 unexpected codec access", {24'd0, cdc_re, cdc_addr}, 32'hFFFF_FFFF);
        end else begin
          op_t e;
          e = exp_q.pop_front();
          chk("R3/R4 access kind", {31'd0, cdc_re}, {31'd0, e.rd});
          chk("R3/R4 address", {25'd0, cdc_addr}, {25'd0, e.addr});
          if (!e.rd) chk("R3 write data", {16'd0, cdc_wdata}, {16'd0, e.data});
        end
      end
      prev_en <= cdc_we || cdc_re;
    end
  end

  function automatic logic [SW-1:0] mk(input logic rd, input logic [6:0] a, input logic [11:0] lo);
    return {rd, a, lo};
  endfunction

  task automatic sw_write(input logic [1:0] sel, input logic [SW-1:0] d);
    sw_sel = sel; sw_wdata = d; sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic sw_read(input logic [1:0] sel, output logic [SW-1:0] v);
    sw_sel = sel; sw_rd = 1'b1;
    #1 v = sw_rdata;
    @(negedge clk);
    sw_rd = 1'b0;
  endtask

  task automatic launch(input logic rd, input logic [6:0] a, input logic [11:0] lo, input logic [15:0] d);
    exp_q.push_back('{rd: rd, addr: a, data: d});
    sw_write(2'd0, mk(rd, a, lo));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200us;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [SW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", {24'd0, slot_flags}, 32'h07);
    sw_read(2'd2, v); chk("R1 reset rx slot 1", {12'd0, v}, 32'd0);
    sw_read(2'd3, v); chk("R1 reset rx slot 2", {12'd0, v}, 32'd0);

    // R2 + R9
    sw_write(2'd1, 20'hABCD5);
    chk("R2/R9 flags after slot-2 write", {24'd0, slot_flags}, 32'h01);
    sw_read(2'd1, v); chk("R2 slot-2 stored", {12'd0, v}, 32'hABCD5);

    // R3 codec write
    launch(1'b0, 7'h12, 12'h0AB, 16'hABCD);
    chk("R3/R7 flags during write", {24'd0, slot_flags}, 32'h80);
    @(negedge clk);
    chk("R7 pending cleared after write", {24'd0, slot_flags}, 32'h00);

    // R4/R5/R6 codec read
    launch(1'b1, 7'h12, 12'h345, 16'h0);
    chk("R6 busy during read", {24'd0, slot_flags}, 32'h98);
    @(negedge clk); @(negedge clk);
    chk("R6 valid after read", {24'd0, slot_flags}, 32'h60);
    sw_read(2'd2, v); chk("R5 rx slot 1 echo", {12'd0, v}, {12'd0, mk(1'b0, 7'h12, 12'h345)});
    chk("R8 rx1 valid cleared", {24'd0, slot_flags}, 32'h40);
    sw_read(2'd3, v); chk("R5 rx slot 2 data", {12'd0, v}, 32'hABCD0);
    chk("R8 rx2 valid cleared", {24'd0, slot_flags}, 32'h00);

    // R7 hold-off of a second launch
    launch(1'b1, 7'h05, 12'h111, 16'h0);
    sw_write(2'd0, mk(1'b1, 7'h12, 12'hFFF));
    @(negedge clk);
    sw_read(2'd2, v); chk("R7 rx slot 1 from first launch", {12'd0, v}, {12'd0, mk(1'b0, 7'h05, 12'h111)});
    sw_read(2'd3, v); chk("R7 rx slot 2 from first launch", {12'd0, v}, 32'h10050);
    sw_read(2'd0, v); chk("R7 slot-1 register unchanged", {12'd0, v}, {12'd0, mk(1'b1, 7'h05, 12'h111)});

    // R8 set wins over a same-cycle clear
    launch(1'b1, 7'h05, 12'h000, 16'h0);
    sw_sel = 2'd2; sw_rd = 1'b1;
    @(negedge clk); @(negedge clk);
    sw_rd = 1'b0;
    chk("R8 completion wins over clear", {31'd0, slot_flags[5]}, 32'd1);

    // R3/R5 field boundaries at extreme values
    sw_write(2'd1, 20'hFFFFF);
    launch(1'b0, 7'h7F, 12'hFFF, 16'hFFFF);
    @(negedge clk);
    launch(1'b1, 7'h7F, 12'hFFF, 16'h0);
    @(negedge clk); @(negedge clk);
    sw_read(2'd2, v); chk("R5 rx slot 1 extreme", {12'd0, v}, 32'h7FFFF);
    sw_read(2'd3, v); chk("R5 rx slot 2 extreme", {12'd0, v}, 32'hFFFF0);

    repeat (3) @(negedge clk);
    chk("R3 all expected accesses seen", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule